// File: doc/BRIEF.md
# Ordered Masked-Compare Trigger Sequencer

The block watches a group of equal-width probe buses and produces one trigger strobe after a programmed chain of conditions has been met in order. Each stage of the chain holds a compare value and a per-bit care mask for every probe, and a per-probe enable. A stage is satisfied when every enabled probe agrees with its value on all cared-for bits. Stages are tried one after another. Any stage after the first may carry a timeout: it must be satisfied within a bounded number of qualified cycles after the stage before it, or the chain falls back to its first stage and keeps watching.

Software loads the stage table while the sequencer is idle. It then pulses `arm` together with the number of stages to use for this run. All comparisons and timeout counting advance only on cycles where `sample_en` is high. With zero stages selected, the sequencer fires on the first qualified cycle after arming. After firing, it stays quiet until it is armed again. A capture buffer would normally consume `trig`.

Top module: `seq_trigger`

## Requirements
- R1: A probe's comparison succeeds when, for every bit whose care-mask bit is 1, the probe bit equals the value bit. Bits whose care-mask bit is 0 are ignored. For example, care 0x040 with value 0x040 matches any probe whose bit 6 is 1. Probe p sits at bits [p*PW +: PW] of every flat probe, value and care bus.
- R2: A stage is satisfied when all probes whose enable bit (bit p of `cfg_pen`) is 1 succeed. A stage with no probe enabled is satisfied on every qualified cycle.
- R3: Stages are checked strictly in index order, starting at stage 0. Stage k is looked at only after stage k-1 has been satisfied. The trigger fires when stage `depth-1` is satisfied, where depth is `arm_depth` latched at arming and limited to NS.
- R4: With a depth of 0, the trigger fires on the first qualified cycle after the arming cycle.
- R5: A stage k≥1 with its timeout enabled and limit T counts qualified cycles from the cycle after stage k-1 was satisfied. It may be satisfied on any of the first T such cycles. If it is not satisfied by the T-th, the chain returns to stage 0 on that cycle, without evaluating stage 0 there, and keeps watching.
- R6: On cycles with `sample_en` low, no stage advances, no timeout count moves and no trigger fires.
- R7: `trig` is high for exactly one clock cycle, starting on the edge that samples the final satisfying cycle. After that, no further trigger occurs until `arm` is pulsed again.
- R8: A pulse on `arm` always restarts the chain at stage 0 with a cleared timeout count, even during a run in progress. Probes are not evaluated on the arming cycle.
- R9: A write to the stage table (`cfg_we`, stage index `cfg_sel`) takes effect only while the sequencer is not armed. Writes made while armed are discarded.
- R10: After reset, `trig` is low, the sequencer is not armed, and every stage table entry is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_en | input | 1 | Qualifier: cycle counts for compares and timeouts |
| probes | input | NP*PW | Flat probe buses, probe p at [p*PW +: PW] |
| arm | input | 1 | Start a run at stage 0 |
| arm_depth | input | $clog2(NS+1) | Number of stages for the run (above NS means NS) |
| cfg_we | input | 1 | Stage table write strobe |
| cfg_sel | input | max(1,$clog2(NS)) | Stage index written |
| cfg_val | input | NP*PW | Compare values for the stage |
| cfg_care | input | NP*PW | Care masks, 1 = bit compared |
| cfg_pen | input | NP | Probe enables for the stage |
| cfg_tmo_en | input | 1 | Timeout enable for the stage |
| cfg_tmo | input | TW | Timeout limit in qualified cycles |
| trig | output | 1 | One-cycle trigger strobe |

## Verification
A wrong stage pointer or a wrong timeout count does not show up directly. It appears at `trig` as a missing, early or late strobe. An off-by-one in the timeout window shifts the allowed match by one qualified cycle. The bench therefore drives a satisfying value exactly on the T-th cycle, and a non-satisfying one there in a separate run. A stage pointer that is not cleared by `arm`, or that skips order, makes `trig` fire on the first out-of-order value, which is visible in the cycle after that value is sampled. Every expected strobe is checked against its exact cycle, so a timing slip of one cycle is reported.

// File: rtl/seq_trigger_pkg.sv
package seq_trigger_pkg;

  // True when a and b agree on every bit selected by care.
  function automatic logic masked_eq(input logic [31:0] a,
                                     input logic [31:0] b,
                                     input logic [31:0] care);
    return ((a ^ b) & care) == 32'd0;
  endfunction

  // Qualified cycles spent in a stage, counting the current one.
  function automatic logic [32:0] next_elapsed(input logic [31:0] timer);
    return {1'b0, timer} + 33'd1;
  endfunction

  // The window is used up once the elapsed count reaches the limit.
  function automatic logic window_spent(input logic [32:0] elapsed,
                                        input logic [31:0] limit);
    return elapsed >= {1'b0, limit};
  endfunction

endpackage

// File: rtl/seq_trigger_cfg.sv
module seq_trigger_cfg #(
  parameter int NP    = 2,
  parameter int PW    = 12,
  parameter int NS    = 4,
  parameter int TW    = 8,
  parameter int SEL_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  armed,
  input  logic                  we,
  input  logic [SEL_W-1:0]      sel,
  input  logic [NP*PW-1:0]      val,
  input  logic [NP*PW-1:0]      care,
  input  logic [NP-1:0]         pen,
  input  logic                  tmo_en,
  input  logic [TW-1:0]         tmo,
  output logic [NS*NP*PW-1:0]   val_q,
  output logic [NS*NP*PW-1:0]   care_q,
  output logic [NS*NP-1:0]      pen_q,
  output logic [NS-1:0]         tmo_en_q,
  output logic [NS*TW-1:0]      tmo_q
);
  localparam int SW = NP * PW;

  logic wr_ok;
  assign wr_ok = we && !armed;

  for (genvar s = 0; s < NS; s++) begin : g_stage
    logic hit_sel;
    assign hit_sel = wr_ok && (sel == SEL_W'(s));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q[s*SW +: SW]  <= '0;
        care_q[s*SW +: SW] <= '0;
        pen_q[s*NP +: NP]  <= '0;
        tmo_en_q[s]        <= 1'b0;
        tmo_q[s*TW +: TW]  <= '0;
      end else if (hit_sel) begin
        val_q[s*SW +: SW]  <= val;
        care_q[s*SW +: SW] <= care;
        pen_q[s*NP +: NP]  <= pen;
        tmo_en_q[s]        <= tmo_en;
        tmo_q[s*TW +: TW]  <= tmo;
      end
    end
  end
endmodule

// File: rtl/seq_trigger_cmp.sv
module seq_trigger_cmp
  import seq_trigger_pkg::*;
#(
  parameter int NP = 2,
  parameter int PW = 12,
  parameter int NS = 4
) (
  input  logic [NP*PW-1:0]    probes,
  input  logic [NS*NP*PW-1:0] val_q,
  input  logic [NS*NP*PW-1:0] care_q,
  input  logic [NS*NP-1:0]    pen_q,
  output logic [NS-1:0]       hit
);
  localparam int SW = NP * PW;

  logic [NS*NP-1:0] probe_ok;

  for (genvar s = 0; s < NS; s++) begin : g_stage
    for (genvar p = 0; p < NP; p++) begin : g_probe
      assign probe_ok[s*NP+p] = !pen_q[s*NP+p] ||
        masked_eq(32'(probes[p*PW +: PW]),
                  32'(val_q[s*SW + p*PW +: PW]),
                  32'(care_q[s*SW + p*PW +: PW]));
    end
    assign hit[s] = &probe_ok[s*NP +: NP];
  end
endmodule

// File: rtl/seq_trigger_fsm.sv
module seq_trigger_fsm
  import seq_trigger_pkg::*;
#(
  parameter int NS    = 4,
  parameter int TW    = 8,
  parameter int IDX_W = 2,
  parameter int CNT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_en,
  input  logic              arm,
  input  logic [CNT_W-1:0]  arm_depth,
  input  logic [NS-1:0]     hit,
  input  logic [NS-1:0]     tmo_en_q,
  input  logic [NS*TW-1:0]  tmo_q,
  output logic              trig,
  output logic              armed,
  output logic [IDX_W-1:0]  ptr,
  output logic [TW-1:0]     timer,
  output logic [CNT_W-1:0]  depth,
  output logic              tmo_active,
  output logic [TW-1:0]     cur_tmo
);
  logic          eval, cur_hit, in_window, is_last, spent;
  logic          fire, advance, restart, count_up;
  logic [32:0]   elapsed;
  logic [CNT_W-1:0] depth_in;

  assign depth_in   = (arm_depth > CNT_W'(NS)) ? CNT_W'(NS) : arm_depth;
  assign cur_hit    = hit[ptr];
  assign cur_tmo    = tmo_q[ptr*TW +: TW];
  assign tmo_active = (ptr != '0) && tmo_en_q[ptr];
  assign elapsed    = next_elapsed(32'(timer));
  assign spent      = tmo_active && window_spent(elapsed, 32'(cur_tmo));
  assign in_window  = !tmo_active || (elapsed <= {1'b0, 32'(cur_tmo)});
  assign is_last    = (CNT_W'(ptr) + CNT_W'(1)) == depth;
  assign eval       = armed && sample_en && !arm;

  assign fire     = eval && ((depth == '0) || (cur_hit && in_window && is_last));
  assign advance  = eval && (depth != '0) && cur_hit && in_window && !is_last;
  assign restart  = eval && (depth != '0) && !(cur_hit && in_window) && spent;
  assign count_up = eval && (depth != '0) && !(cur_hit && in_window) &&
                    tmo_active && !spent;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig  <= 1'b0;
      armed <= 1'b0;
      ptr   <= '0;
      timer <= '0;
      depth <= '0;
    end else begin
      trig <= fire;
      if (arm) begin
        armed <= 1'b1;
        ptr   <= '0;
        timer <= '0;
        depth <= depth_in;
      end else if (fire) begin
        armed <= 1'b0;
        ptr   <= '0;
        timer <= '0;
      end else if (advance) begin
        ptr   <= ptr + IDX_W'(1);
        timer <= '0;
      end else if (restart) begin
        ptr   <= '0;
        timer <= '0;
      end else if (count_up) begin
        timer <= elapsed[TW-1:0];
      end
    end
  end
endmodule

// File: rtl/seq_trigger.sv
module seq_trigger #(
  parameter int NP = 2,
  parameter int PW = 12,
  parameter int NS = 4,
  parameter int TW = 8,
  localparam int SEL_W = (NS > 1) ? $clog2(NS) : 1,
  localparam int CNT_W = $clog2(NS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sample_en,
  input  logic [NP*PW-1:0]   probes,
  input  logic               arm,
  input  logic [CNT_W-1:0]   arm_depth,
  input  logic               cfg_we,
  input  logic [SEL_W-1:0]   cfg_sel,
  input  logic [NP*PW-1:0]   cfg_val,
  input  logic [NP*PW-1:0]   cfg_care,
  input  logic [NP-1:0]      cfg_pen,
  input  logic               cfg_tmo_en,
  input  logic [TW-1:0]      cfg_tmo,
  output logic               trig
);
  localparam int IDX_W = SEL_W;

  logic [NS*NP*PW-1:0] val_q, care_q;
  logic [NS*NP-1:0]    pen_q;
  logic [NS-1:0]       tmo_en_q, stage_hit;
  logic [NS*TW-1:0]    tmo_q;
  logic                armed_w, tmo_active_w;
  logic [IDX_W-1:0]    ptr_w;
  logic [TW-1:0]       timer_w, cur_tmo_w;
  logic [CNT_W-1:0]    depth_w;

  seq_trigger_cfg #(.NP(NP), .PW(PW), .NS(NS), .TW(TW), .SEL_W(SEL_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .armed(armed_w), .we(cfg_we), .sel(cfg_sel),
    .val(cfg_val), .care(cfg_care), .pen(cfg_pen), .tmo_en(cfg_tmo_en),
    .tmo(cfg_tmo), .val_q(val_q), .care_q(care_q), .pen_q(pen_q),
    .tmo_en_q(tmo_en_q), .tmo_q(tmo_q)
  );

  seq_trigger_cmp #(.NP(NP), .PW(PW), .NS(NS)) u_cmp (
    .probes(probes), .val_q(val_q), .care_q(care_q), .pen_q(pen_q),
    .hit(stage_hit)
  );

  seq_trigger_fsm #(.NS(NS), .TW(TW), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .arm(arm),
    .arm_depth(arm_depth), .hit(stage_hit), .tmo_en_q(tmo_en_q),
    .tmo_q(tmo_q), .trig(trig), .armed(armed_w), .ptr(ptr_w),
    .timer(timer_w), .depth(depth_w), .tmo_active(tmo_active_w),
    .cur_tmo(cur_tmo_w)
  );
endmodule

// File: rtl/seq_trigger_chk.sv
module seq_trigger_chk #(
  parameter int TW    = 8,
  parameter int IDX_W = 2,
  parameter int CNT_W = 3,
  parameter int CFG_W = 96
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sample_en,
  input logic             arm,
  input logic             trig,
  input logic             armed,
  input logic [IDX_W-1:0] ptr,
  input logic [TW-1:0]    timer,
  input logic [CNT_W-1:0] depth,
  input logic             tmo_active,
  input logic [TW-1:0]    cur_tmo,
  input logic [CFG_W-1:0] cfg_val
);
  a_r7_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig);

  a_r7_disarm_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> !armed);

  a_r6_hold_when_unqualified: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_en && !arm) |=> (!trig && $stable(ptr) && $stable(timer)));

  a_r3_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && depth != '0) |-> (CNT_W'(ptr) < depth));

  a_r5_timer_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && tmo_active) |-> ((timer < cur_tmo) || (timer == '0)));

  a_r9_table_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> $stable(cfg_val));

  a_r8_arm_restart: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (armed && ptr == '0 && timer == '0 && !trig));
endmodule

bind seq_trigger seq_trigger_chk #(
  .TW(TW), .IDX_W(IDX_W), .CNT_W(CNT_W), .CFG_W(NS*NP*PW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .arm(arm), .trig(trig),
  .armed(armed_w), .ptr(ptr_w), .timer(timer_w), .depth(depth_w),
  .tmo_active(tmo_active_w), .cur_tmo(cur_tmo_w), .cfg_val(val_q)
);

// File: tb/seq_trigger_tb.sv
module seq_trigger_tb;
  localparam int NP = 2, PW = 12, NS = 4, TW = 8;
  localparam int SEL_W = 2, CNT_W = 3;

  logic clk = 1'b0, rst_n = 1'b0, sample_en = 1'b0, arm = 1'b0, cfg_we = 1'b0;
  logic cfg_tmo_en = 1'b0;
  logic [NP*PW-1:0] probes = '0, cfg_val = '0, cfg_care = '0;
  logic [CNT_W-1:0] arm_depth = '0;
  logic [SEL_W-1:0] cfg_sel = '0;
  logic [NP-1:0]    cfg_pen = '0;
  logic [TW-1:0]    cfg_tmo = '0;
  logic trig;

  int cyc = 0, checks = 0, errors = 0, trig_seen = 0;
  bit finished = 0;
  int    exp_cyc[$];
  string exp_req[$];

  seq_trigger #(.NP(NP), .PW(PW), .NS(NS), .TW(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .probes(probes),
    .arm(arm), .arm_depth(arm_depth), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_val(cfg_val), .cfg_care(cfg_care), .cfg_pen(cfg_pen),
    .cfg_tmo_en(cfg_tmo_en), .cfg_tmo(cfg_tmo), .trig(trig)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: pops expected strobes and compares against trig
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (trig) begin
        trig_seen++;
        checks++;
        if (exp_cyc.size() == 0) begin
          errors++;
          $display("FAIL R7 unexpected trigger at cycle %0d: actual 1 expected 0", cyc);
        end else begin
          if (exp_cyc[0] != cyc) begin
            errors++;
            $display("FAIL %s trigger cycle: actual %0d expected %0d", exp_req[0], cyc, exp_cyc[0]);
          end
          void'(exp_cyc.pop_front());
          void'(exp_req.pop_front());
        end
      end else if (exp_cyc.size() > 0 && exp_cyc[0] <= cyc) begin
        checks++;
        errors++;
        $display("FAIL %s missing trigger at cycle %0d: actual 0 expected 1", exp_req[0], exp_cyc[0]);
        void'(exp_cyc.pop_front());
        void'(exp_req.pop_front());
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic tick(input int p0, input int p1, input bit sen);
    probes    = {PW'(p1), PW'(p0)};
    sample_en = sen;
    step();
  endtask

  task automatic expect_fire(input string req);
    exp_cyc.push_back(cyc);
    exp_req.push_back(req);
  endtask

  task automatic cfg_stage(input int s, input int v0, input int c0, input int v1,
                           input int c1, input int pen, input bit ten, input int t);
    cfg_sel = SEL_W'(s);
    cfg_val = {PW'(v1), PW'(v0)};
    cfg_care = {PW'(c1), PW'(c0)};
    cfg_pen = NP'(pen);
    cfg_tmo_en = ten;
    cfg_tmo = TW'(t);
    cfg_we = 1'b1;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic do_arm(input int d);
    arm = 1'b1;
    arm_depth = CNT_W'(d);
    sample_en = 1'b1;
    step();
    arm = 1'b0;
  endtask

  // Idle a few cycles, then compare the number of strobes in the window
  task automatic close_window(input string req, input int base, input int want);
    for (int i = 0; i < 3; i++) tick(0, 4095, 1'b0);
    checks++;
    if (trig_seen - base != want) begin
      errors++;
      $display("FAIL %s strobe count: actual %0d expected %0d", req, trig_seen - base, want);
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R10: reset state
    checks++;
    if (trig !== 1'b0) begin
      errors++;
      $display("FAIL R10 trig after reset: actual %0b expected 0", trig);
    end

    // R4 / R6: immediate mode waits for the first qualified cycle
    base = trig_seen;
    do_arm(0);
    tick(0, 0, 1'b0);
    tick(0, 0, 1'b0);
    tick(0, 0, 1'b1); expect_fire("R4");
    close_window("R4", base, 1);

    // R1 / R7: masked compare on probe 1, probe 0 disabled
    cfg_stage(0, 0, 0, 'h040, 'h040, 2'b10, 1'b0, 0);
    base = trig_seen;
    do_arm(1);
    tick(7, 'h03F, 1'b1);
    tick(7, 'h080, 1'b1);
    tick(7, 'h0C0, 1'b1); expect_fire("R1");
    tick(7, 'h0C0, 1'b1);
    tick(7, 'h0C0, 1'b1);
    close_window("R7", base, 1);
    base = trig_seen;
    do_arm(1);
    tick(0, 'h07F, 1'b1); expect_fire("R1");
    close_window("R1", base, 1);

    // R2: both probes enabled, full compare
    cfg_stage(0, 'h123, 'hFFF, 'h00A, 'hFFF, 2'b11, 1'b0, 0);
    base = trig_seen;
    do_arm(1);
    tick('h123, 'h00B, 1'b1);
    tick('h124, 'h00A, 1'b1);
    tick('h123, 'h00A, 1'b1); expect_fire("R2");
    close_window("R2", base, 1);

    // R2: stage with no enabled probe matches at once
    cfg_stage(0, 'h123, 'hFFF, 'h00A, 'hFFF, 2'b00, 1'b0, 0);
    base = trig_seen;
    do_arm(1);
    tick('h555, 'h777, 1'b1); expect_fire("R2");
    close_window("R2", base, 1);

    // R5: 0 followed by 5 within 5 qualified cycles
    cfg_stage(0, 0, 0, 0, 'hFFF, 2'b10, 1'b0, 0);
    cfg_stage(1, 0, 0, 5, 'hFFF, 2'b10, 1'b1, 5);
    base = trig_seen;
    do_arm(2);
    for (int v = 0; v <= 4; v++) tick(0, v, 1'b1);
    tick(0, 5, 1'b1); expect_fire("R5");
    close_window("R5", base, 1);

    // R5: window missed, restart, later success
    base = trig_seen;
    do_arm(2);
    for (int v = 0; v <= 4; v++) tick(0, v, 1'b1);
    tick(0, 6, 1'b1);
    tick(0, 5, 1'b1);
    close_window("R5", base, 0);
    base = trig_seen;
    tick(0, 0, 1'b1);
    tick(0, 5, 1'b1); expect_fire("R5");
    close_window("R5", base, 1);

    // R6: unqualified cycles do not count toward the timeout
    base = trig_seen;
    do_arm(2);
    tick(0, 0, 1'b1);
    for (int i = 0; i < 10; i++) tick(0, 5, 1'b0);
    for (int v = 1; v <= 4; v++) tick(0, v, 1'b1);
    tick(0, 5, 1'b1); expect_fire("R6");
    close_window("R6", base, 1);

    // R3: three stages in order
    cfg_stage(0, 0, 0, 1, 'hFFF, 2'b10, 1'b0, 0);
    cfg_stage(1, 0, 0, 2, 'hFFF, 2'b10, 1'b0, 0);
    cfg_stage(2, 0, 0, 3, 'hFFF, 2'b10, 1'b0, 0);
    base = trig_seen;
    do_arm(3);
    tick(0, 3, 1'b1);
    tick(0, 2, 1'b1);
    tick(0, 1, 1'b1);
    tick(0, 3, 1'b1);
    close_window("R3", base, 0);
    base = trig_seen;
    tick(0, 2, 1'b1);
    tick(0, 3, 1'b1); expect_fire("R3");
    close_window("R3", base, 1);

    // R8: re-arm mid-run restarts at stage 0
    base = trig_seen;
    do_arm(3);
    tick(0, 1, 1'b1);
    tick(0, 2, 1'b1);
    do_arm(3);
    tick(0, 3, 1'b1);
    tick(0, 2, 1'b1);
    close_window("R8", base, 0);
    base = trig_seen;
    tick(0, 1, 1'b1);
    tick(0, 2, 1'b1);
    tick(0, 3, 1'b1); expect_fire("R8");
    close_window("R8", base, 1);

    // R9: table write while armed is discarded
    cfg_stage(0, 0, 0, 'h010, 'hFFF, 2'b10, 1'b0, 0);
    base = trig_seen;
    do_arm(1);
    sample_en = 1'b0;
    cfg_stage(0, 0, 0, 'h020, 'hFFF, 2'b10, 1'b0, 0);
    tick(0, 'h020, 1'b1);
    close_window("R9", base, 0);
    base = trig_seen;
    tick(0, 'h010, 1'b1); expect_fire("R9");
    close_window("R9", base, 1);
    // R9: write when idle is accepted
    cfg_stage(0, 0, 0, 'h020, 'hFFF, 2'b10, 1'b0, 0);
    base = trig_seen;
    do_arm(1);
    tick(0, 'h010, 1'b1);
    tick(0, 'h020, 1'b1); expect_fire("R9");
    close_window("R9", base, 1);

    checks++;
    if (exp_cyc.size() != 0) begin
      errors++;
      $display("FAIL R7 pending strobes: actual %0d expected 0", exp_cyc.size());
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule